// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

The block sits between a clocked host and an external asynchronous static RAM of 128K sixteen-bit words with independently enabled lower and upper byte lanes. The host hands over one word request at a time through a valid/ready handshake: a direction bit, a 17-bit word address, 16 bits of write data and a two-bit lane mask. The controller turns each request into a chip-enable, write-strobe or output-enable sequence on the memory pins. For reads it returns the captured word with a single-clock valid pulse.

All strobe phases are whole clocks. Each is sized at elaboration from nanosecond minimums and a clock-period parameter, by rounding up with a floor of one clock. A write runs through three states. `WR_SETUP` puts the address on the pins with the write strobe high. `WR_PULSE` holds the strobe low and drives the data. `WR_HOLD` raises the strobe while the address and data stay put. A read is a single `RD_ACCESS` state with output enable low, and the bus is sampled on its last clock. When the direction of a request differs from the one before it, `IDLE` first passes through `TURN`. In `TURN` the chip is deselected for long enough that whichever side drove the bus last has let go.

State transitions: `IDLE` moves to `TURN` on an accepted request that changes direction, otherwise straight to `WR_SETUP` or `RD_ACCESS`. `TURN` moves to `WR_SETUP` or `RD_ACCESS` once its count is done. `WR_SETUP` moves to `WR_PULSE`, then `WR_HOLD`, then `IDLE`. `RD_ACCESS` moves to `IDLE`.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset the chip is deselected (`mem_ce_n`=1, `mem_ce2`=0), both strobes are high, the data bus is not driven, both lane enables are high, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request is taken on a clock where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the controller is back in `IDLE`, and one idle clock follows every operation.
- R3: A write spends `max(1, ceil(tAS/T))` clocks in `WR_SETUP` with the strobe high, then `max(ceil(tWP/T), ceil(tDW/T), ceil(tAW/T) - setup clocks, 1)` clocks with `mem_we_n` low. Write data stays stable while the strobe is low (with defaults: 1 and 6 clocks).
- R4: A write keeps the chip selected for `setup + pulse + hold` clocks. Hold is at least `max(1, ceil(tWR/T))` and is stretched so that the total is at least `ceil(tWC/T)` (with defaults: 8 clocks).
- R5: `mem_dq_oe` is high only in `WR_PULSE` and `WR_HOLD`, never while `mem_oe_n` is low. The data is still driven on the clock the write strobe rises.
- R6: Mask bit 0 drives `mem_lane_n[0]` (data bits 7:0) and mask bit 1 drives `mem_lane_n[1]` (bits 15:8). A set bit pulls the enable low for the whole access, so a write changes only the enabled lanes and a mask of 0 changes nothing.
- R7: A read holds `mem_oe_n` low and `mem_we_n` high for `max(ceil(tAA/T), ceil(tOE/T), ceil(tRC/T))` clocks (7 with defaults) and samples `mem_dq_in` on the last of them.
- R8: `rsp_valid` is high for exactly one clock, on the clock after the last read-access clock. `rsp_rdata` carries the sampled lanes whose mask bit was set and zero in the others.
- R9: An operation whose direction differs from the previous accepted one is preceded by `max(1, ceil(tFLOAT/T))` deselected `TURN` clocks (4 with defaults). Same-direction operations and the first operation after reset get none.
- R10: `mem_addr` changes only while `mem_we_n` is high and was high on the previous clock, and it holds the request address for the whole access.
- R11: Either strobe is low only while the chip is selected (`mem_ce_n`=0 and `mem_ce2`=1), and the chip is selected only in the four access states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 lower byte, bit 1 upper byte |
| rsp_valid | output | 1 | One-clock read-data strobe |
| rsp_rdata | output | 16 | Read data, unmasked lanes zero |
| mem_addr | output | 17 | Address to the RAM |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_lane_n | output | 2 | Active-low lane enables, bit 0 lower byte |
| mem_dq_out | output | 16 | Data toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 16 | Data from the RAM |

## Verification
The assertions assume that the host changes request fields only at a clock edge. They also assume that the RAM answers a read only after it has seen the output enable for the access time. The bench keeps to both. It drives requests at the falling edge and holds them steady until acceptance. Its RAM model puts the stored word on the bus only once output enable has been low for one clock less than the read phase, and puts a filler pattern there otherwise. A sampling point one clock early is therefore caught as wrong data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_RD_ACCESS
    } ctrl_state_e;

    typedef struct packed {
        logic ce_n;
        logic ce2;
        logic we_n;
        logic oe_n;
        logic drive;
    } pin_ctrl_t;

    localparam pin_ctrl_t PINS_IDLE = '{ce_n: 1'b1, ce2: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

    // whole clocks covering a nanosecond minimum, never fewer than one
    function automatic int unsigned clocks_for(input int unsigned ns, input int unsigned period);
        int unsigned r;
        r = (ns + period - 1) / period;
        if (r < 1) r = 1;
        return r;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] len,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    assign last = (cnt_q == len - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (!last) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              write_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [LANES-1:0]  mask_i,
    output logic              started_q,
    output logic              write_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [LANES-1:0]  mask_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            started_q <= 1'b0;
            write_q   <= 1'b0;
            addr_q    <= '0;
            wdata_q   <= '0;
            mask_q    <= '0;
        end else if (load) begin
            started_q <= 1'b1;
            write_q   <= write_i;
            addr_q    <= addr_i;
            wdata_q   <= wdata_i;
            mask_q    <= mask_i;
        end
    end
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [LANES-1:0]  mask,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int unsigned LANE_W = DATA_W / LANES;

    logic [DATA_W-1:0] masked;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign masked[l*LANE_W +: LANE_W] = mask[l] ? dq_in[l*LANE_W +: LANE_W] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) rsp_rdata <= masked;
        end
    end
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 8,
    parameter int unsigned ADDR_W        = 17,
    parameter int unsigned DATA_W        = 16,
    parameter int unsigned LANES         = 2,
    parameter int unsigned T_AS_NS       = 0,
    parameter int unsigned T_WP_NS       = 30,
    parameter int unsigned T_AW_NS       = 55,
    parameter int unsigned T_DW_NS       = 25,
    parameter int unsigned T_WR_NS       = 0,
    parameter int unsigned T_WC_NS       = 55,
    parameter int unsigned T_AA_NS       = 55,
    parameter int unsigned T_OE_NS       = 30,
    parameter int unsigned T_RC_NS       = 55,
    parameter int unsigned T_FLOAT_NS    = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [LANES-1:0]  mem_lane_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    // phase lengths in clocks
    localparam int unsigned AW_CLKS    = clocks_for(T_AW_NS, CLK_PERIOD_NS);
    localparam int unsigned SETUP_CLKS = clocks_for(T_AS_NS, CLK_PERIOD_NS);
    localparam int unsigned AW_REST    = (AW_CLKS > SETUP_CLKS) ? AW_CLKS - SETUP_CLKS : 1;
    localparam int unsigned PULSE_CLKS = umax(umax(clocks_for(T_WP_NS, CLK_PERIOD_NS),
                                                   clocks_for(T_DW_NS, CLK_PERIOD_NS)), AW_REST);
    localparam int unsigned WC_CLKS    = clocks_for(T_WC_NS, CLK_PERIOD_NS);
    localparam int unsigned WC_REST    = (WC_CLKS > SETUP_CLKS + PULSE_CLKS) ?
                                         WC_CLKS - SETUP_CLKS - PULSE_CLKS : 1;
    localparam int unsigned HOLD_CLKS  = umax(clocks_for(T_WR_NS, CLK_PERIOD_NS), WC_REST);
    localparam int unsigned READ_CLKS  = umax(clocks_for(T_AA_NS, CLK_PERIOD_NS),
                                              umax(clocks_for(T_OE_NS, CLK_PERIOD_NS),
                                                   clocks_for(T_RC_NS, CLK_PERIOD_NS)));
    localparam int unsigned TURN_CLKS  = clocks_for(T_FLOAT_NS, CLK_PERIOD_NS);
    localparam int unsigned LONGEST    = umax(umax(SETUP_CLKS, PULSE_CLKS),
                                              umax(umax(HOLD_CLKS, READ_CLKS), TURN_CLKS));
    localparam int unsigned CNT_W      = $clog2(LONGEST + 1);

    ctrl_state_e       state_q;
    ctrl_state_e       state_d;
    logic              accept;
    logic              need_turn;
    logic              phase_last;
    logic [CNT_W-1:0]  phase_len;
    logic              started_q;
    logic              op_write_q;
    logic [ADDR_W-1:0] op_addr_q;
    logic [DATA_W-1:0] op_wdata_q;
    logic [LANES-1:0]  op_mask_q;
    logic [LANES-1:0]  mask_next;
    pin_ctrl_t         pins_d;
    pin_ctrl_t         pins_q;
    logic [LANES-1:0]  lanes_d;
    logic [LANES-1:0]  lanes_q;
    logic              capture;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign need_turn = started_q && (op_write_q != req_write);
    assign mask_next = accept ? req_mask : op_mask_q;
    assign capture   = (state_q == ST_RD_ACCESS) && phase_last;

    sram_req_latch #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .write_i   (req_write),
        .addr_i    (req_addr),
        .wdata_i   (req_wdata),
        .mask_i    (req_mask),
        .started_q (started_q),
        .write_q   (op_write_q),
        .addr_q    (op_addr_q),
        .wdata_q   (op_wdata_q),
        .mask_q    (op_mask_q)
    );

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_d != state_q),
        .len     (phase_len),
        .last    (phase_last)
    );

    sram_rd_capture #(
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .mask      (op_mask_q),
        .dq_in     (mem_dq_in),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // phase length of the current state
    always_comb begin
        unique case (state_q)
            ST_TURN:      phase_len = CNT_W'(TURN_CLKS);
            ST_WR_SETUP:  phase_len = CNT_W'(SETUP_CLKS);
            ST_WR_PULSE:  phase_len = CNT_W'(PULSE_CLKS);
            ST_WR_HOLD:   phase_len = CNT_W'(HOLD_CLKS);
            ST_RD_ACCESS: phase_len = CNT_W'(READ_CLKS);
            default:      phase_len = CNT_W'(1);
        endcase
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (need_turn)      state_d = ST_TURN;
                    else if (req_write) state_d = ST_WR_SETUP;
                    else                state_d = ST_RD_ACCESS;
                end
            end
            ST_TURN: begin
                if (phase_last) state_d = op_write_q ? ST_WR_SETUP : ST_RD_ACCESS;
            end
            ST_WR_SETUP: begin
                if (phase_last) state_d = ST_WR_PULSE;
            end
            ST_WR_PULSE: begin
                if (phase_last) state_d = ST_WR_HOLD;
            end
            ST_WR_HOLD: begin
                if (phase_last) state_d = ST_IDLE;
            end
            ST_RD_ACCESS: begin
                if (phase_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // pin decode from the state being entered, registered so the pins never glitch
    always_comb begin
        pins_d  = PINS_IDLE;
        lanes_d = '1;
        unique case (state_d)
            ST_WR_SETUP: begin
                pins_d.ce_n = 1'b0;
                pins_d.ce2  = 1'b1;
                lanes_d     = ~mask_next;
            end
            ST_WR_PULSE: begin
                pins_d.ce_n  = 1'b0;
                pins_d.ce2   = 1'b1;
                pins_d.we_n  = 1'b0;
                pins_d.drive = 1'b1;
                lanes_d      = ~mask_next;
            end
            ST_WR_HOLD: begin
                pins_d.ce_n  = 1'b0;
                pins_d.ce2   = 1'b1;
                pins_d.drive = 1'b1;
                lanes_d      = ~mask_next;
            end
            ST_RD_ACCESS: begin
                pins_d.ce_n = 1'b0;
                pins_d.ce2  = 1'b1;
                pins_d.oe_n = 1'b0;
                lanes_d     = ~mask_next;
            end
            default: begin
                pins_d  = PINS_IDLE;
                lanes_d = '1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_q  <= PINS_IDLE;
            lanes_q <= '1;
        end else begin
            pins_q  <= pins_d;
            lanes_q <= lanes_d;
        end
    end

    assign mem_ce_n   = pins_q.ce_n;
    assign mem_ce2    = pins_q.ce2;
    assign mem_we_n   = pins_q.we_n;
    assign mem_oe_n   = pins_q.oe_n;
    assign mem_dq_oe  = pins_q.drive;
    assign mem_lane_n = lanes_q;
    assign mem_addr   = op_addr_q;
    assign mem_dq_out = op_wdata_q;

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
    parameter int unsigned CLK_NS     = 8,
    parameter int unsigned T_WP_NS    = 30,
    parameter int unsigned T_FLOAT_NS = 25,
    parameter int unsigned ADDR_W     = 17,
    parameter int unsigned DATA_W     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_ce2,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);
    localparam int unsigned WP_MIN    = ((T_WP_NS + CLK_NS - 1) / CLK_NS < 1) ? 1 : (T_WP_NS + CLK_NS - 1) / CLK_NS;
    localparam int unsigned FLOAT_MIN = ((T_FLOAT_NS + CLK_NS - 1) / CLK_NS < 1) ? 1 : (T_FLOAT_NS + CLK_NS - 1) / CLK_NS;
    localparam logic [7:0]  SAT       = 8'hFF;

    logic       selected;
    logic [7:0] we_low_cnt;
    logic [7:0] since_drive;
    logic [7:0] since_read;

    assign selected = !mem_ce_n && mem_ce2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_cnt  <= '0;
            since_drive <= SAT;
            since_read  <= SAT;
        end else begin
            we_low_cnt  <= mem_we_n ? 8'd0 : ((we_low_cnt == SAT) ? SAT : we_low_cnt + 8'd1);
            since_drive <= mem_dq_oe ? 8'd0 : ((since_drive == SAT) ? SAT : since_drive + 8'd1);
            since_read  <= !mem_oe_n ? 8'd0 : ((since_read == SAT) ? SAT : since_read + 8'd1);
        end
    end

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R2

    AST_WE_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_cnt >= 8'(WP_MIN))); // R3

    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_out)); // R3

    AST_NO_STROBE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n)); // R5

    AST_DRIVE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && selected)); // R5

    AST_DRIVE_AT_WE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dq_oe); // R5

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R8

    AST_FLOAT_BEFORE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> (since_drive >= 8'(FLOAT_MIN))); // R9

    AST_FLOAT_BEFORE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (since_read >= 8'(FLOAT_MIN))); // R9

    AST_ADDR_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_addr) |-> (mem_we_n && $past(mem_we_n))); // R10

    AST_STROBE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || !mem_oe_n) |-> selected); // R11

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(
    .CLK_NS     (CLK_PERIOD_NS),
    .T_WP_NS    (T_WP_NS),
    .T_FLOAT_NS (T_FLOAT_NS),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_ce2    (mem_ce2),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_strobe_ctrl_bench.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_bench;
    localparam int PERIOD = 8;
    localparam int NADDR  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [1:0]  mem_lane_n;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = 16'hA5A5;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #(PERIOD/2) clk = ~clk;

    sram_strobe_ctrl u_sram_strobe_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_lane_n(mem_lane_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    function automatic int cdiv(input int ns);
        int r;
        r = (ns + PERIOD - 1) / PERIOD;
        return (r < 1) ? 1 : r;
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int EXP_SETUP = 1;
    int exp_pulse, exp_sel_wr, exp_read, exp_turn;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // RAM model: writes on the rising write strobe, data shown only after the access time
    logic [15:0] model_mem [logic [16:0]];
    int  oe_cnt = 0;
    bit  we_was_low = 1'b0;
    int  model_errs = 0;
    wire sel = !mem_ce_n && mem_ce2;

    always @(posedge clk) oe_cnt <= (sel && !mem_oe_n && mem_we_n) ? oe_cnt + 1 : 0;

    always @(negedge clk) begin
        logic [15:0] w;
        if (sel && mem_we_n && we_was_low) begin
            if (!mem_dq_oe) model_errs++;
            w = model_mem.exists(mem_addr) ? model_mem[mem_addr] : 16'h0000;
            if (!mem_lane_n[0]) w[7:0]  = mem_dq_out[7:0];
            if (!mem_lane_n[1]) w[15:8] = mem_dq_out[15:8];
            model_mem[mem_addr] = w;
        end
        we_was_low = sel && !mem_we_n;
        if (sel && !mem_oe_n && mem_we_n && oe_cnt >= exp_read - 1) begin
            w = model_mem.exists(mem_addr) ? model_mem[mem_addr] : 16'h0000;
            mem_dq_in <= {mem_lane_n[1] ? 8'h5A : w[15:8], mem_lane_n[0] ? 8'h5A : w[7:0]};
        end else begin
            mem_dq_in <= 16'hA5A5;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    int          r_desel, r_we, r_oe, r_sel, r_setup;
    logic [15:0] r_data;

    task automatic do_op(input bit wr, input logic [16:0] a, input logic [15:0] d, input logic [1:0] m);
        bit done = 1'b0;
        bit bad_pins = 1'b0;
        r_desel = 0; r_we = 0; r_oe = 0; r_sel = 0; r_setup = 0; r_data = '0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R2 ready low after accept", {31'd0, req_ready}, 0);
        for (int k = 0; k < 100 && !done; k++) begin
            if (k > 0) @(negedge clk);
            if (!sel) r_desel++;
            else      r_sel++;
            if (!mem_we_n) r_we++;
            if (!mem_oe_n) r_oe++;
            if (sel && mem_we_n && mem_oe_n && !mem_dq_oe) r_setup++;
            if ((!mem_we_n || !mem_oe_n) && !sel) bad_pins = 1'b1;
            if (sel && (mem_addr != a || mem_lane_n != ~m)) bad_pins = 1'b1;
            if (wr ? req_ready : rsp_valid) begin
                done = 1'b1;
                r_data = rsp_rdata;
            end
        end
        check(done, "R2 operation completes", {31'd0, done}, 1);
        check(!bad_pins, "R6 R10 R11 pins during access", {31'd0, bad_pins}, 0);
        if (!wr) begin
            @(negedge clk);
            check(!rsp_valid, "R8 valid one clock", {31'd0, rsp_valid}, 0);
        end
    endtask

    logic [15:0] exp_mem [NADDR];

    function automatic logic [16:0] addr_of(input int i);
        return (i == NADDR - 1) ? 17'h1FFFF : 17'((i * 40503) & 17'h1FFFF);
    endfunction
    function automatic logic [15:0] pat(input int i, input int s);
        return 16'((i * 9029 + s * 4099 + 16'h1234) ^ (s << 11));
    endfunction
    function automatic logic [15:0] lanes_of(input logic [1:0] m);
        return {{8{m[1]}}, {8{m[0]}}};
    endfunction

    initial begin
        bit prev_wr;
        exp_pulse  = imax(imax(cdiv(30), cdiv(25)), cdiv(55) - EXP_SETUP);
        exp_sel_wr = imax(EXP_SETUP + exp_pulse + cdiv(0), cdiv(55));
        exp_read   = imax(cdiv(55), imax(cdiv(30), cdiv(55)));
        exp_turn   = cdiv(25);

        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(mem_ce_n && !mem_ce2, "R1 deselected", {30'd0, mem_ce_n, mem_ce2}, 2);
        check(mem_we_n && mem_oe_n, "R1 strobes high", {30'd0, mem_we_n, mem_oe_n}, 3);
        check(!mem_dq_oe && mem_lane_n == 2'b11, "R1 bus idle", {29'd0, mem_dq_oe, mem_lane_n}, 3);
        check(req_ready && !rsp_valid, "R1 ready idle", {30'd0, req_ready, rsp_valid}, 2);
        rst_n = 1'b1;

        // full-word writes: timing of write phases, no turnaround between writes
        for (int i = 0; i < NADDR; i++) begin
            do_op(1'b1, addr_of(i), pat(i, 0), 2'b11);
            exp_mem[i] = pat(i, 0);
            check(r_we == exp_pulse, "R3 write pulse clocks", r_we, exp_pulse);
            check(r_setup == EXP_SETUP, "R3 setup clocks", r_setup, EXP_SETUP);
            check(r_sel == exp_sel_wr, "R4 write select clocks", r_sel, exp_sel_wr);
            check(r_desel == 1, "R9 no turn write after write", r_desel, 1);
        end
        prev_wr = 1'b1;

        // masked writes followed by full and masked reads
        for (int i = 0; i < NADDR; i++) begin
            for (int mi = 0; mi < 4; mi++) begin
                logic [1:0]  m = 2'(mi);
                logic [15:0] d = pat(i, mi + 1);
                do_op(1'b1, addr_of(i), d, m);
                check(r_desel == (prev_wr ? 1 : exp_turn + 1), "R9 turn before write", r_desel,
                      prev_wr ? 1 : exp_turn + 1);
                exp_mem[i] = (exp_mem[i] & ~lanes_of(m)) | (d & lanes_of(m));

                do_op(1'b0, addr_of(i), 16'h0, 2'b11);
                check(r_desel == exp_turn + 1, "R9 turn before read", r_desel, exp_turn + 1);
                check(r_oe == exp_read, "R7 read access clocks", r_oe, exp_read);
                check(r_data == exp_mem[i], "R6 merged word", r_data, exp_mem[i]);

                do_op(1'b0, addr_of(i), 16'h0, m);
                check(r_desel == 1, "R9 no turn read after read", r_desel, 1);
                check(r_data == (exp_mem[i] & lanes_of(m)), "R8 masked read lanes", r_data,
                      exp_mem[i] & lanes_of(m));
                prev_wr = 1'b0;
            end
        end
        check(model_errs == 0, "R5 data driven at write end", model_errs, 0);
        finish_run();
    end
endmodule